// File: doc/BRIEF.md
# Pipeline hazard and forwarding unit

This block is the control logic for a five-stage in-order integer pipeline with fetch, decode, execute, memory and writeback stages. Each cycle it takes the register fields of the instruction in decode (two sources `rs` and `rt`, plus `rd`) and that instruction's control flags. It keeps its own copy of the destination register, write enable and load flag as each instruction moves through execute, memory and writeback. The destination therefore travels with the instruction that produces it.

From this tracked state it drives the operand-select controls of the two execute-stage operand muxes, so that an operand comes from the newest producer rather than from a stale register-file read. It also drives a bypass flag for each decode source that covers a register-file write and read of the same register in one cycle. When a load in execute produces a register that the instruction in decode reads, it holds the PC and the decode register for one cycle and turns the instruction entering execute into a bubble. The datapath, ALU and memories sit outside the block.

Top module: `hzd_unit`

## Requirements
- R1: The destination of an instruction is `id_rt_i` when `id_dst_rt_i` is 1 (loads, immediates) and `id_rd_i` when it is 0 (register format). The unit captures it when the instruction enters execute.
- R2: An execute source equal to the memory-stage destination selects the memory-stage result: `fwd_a_o`/`fwd_b_o` = 2'b10.
- R3: An execute source equal only to the writeback-stage destination selects the writeback result, code 2'b01. With no match the code is 2'b00, which selects the register file.
- R4: When both the memory and writeback stages match the same source, the memory stage wins.
- R5: Register 0 is never forwarded, never bypassed and never causes a stall.
- R6: Only a producer whose write enable is 1 takes part in any forwarding, bypass or stall comparison.
- R7: `id_byp_a_o` (for `rs`) and `id_byp_b_o` (for `rt`) are 1 when the writeback stage writes the register that the decode source reads, so the read returns the value written in the same cycle.
- R8: A load in execute (load flag and write enable both 1) whose destination equals the decode `rs` or `rt` raises `pc_hold_o`, `ifid_hold_o` and `ex_flush_o` for exactly one cycle. The next cycle execute holds a bubble.
- R9: After the one-bubble stall, the dependent instruction in execute receives the load result through the writeback path (code 2'b01).
- R10: After reset the pipeline is empty: all selects 00, no bypass, no hold, no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_rs_i | input | 5 | First source register of the decode instruction |
| id_rt_i | input | 5 | Second source register of the decode instruction |
| id_rd_i | input | 5 | Register-format destination field of the decode instruction |
| id_reg_we_i | input | 1 | Decode instruction writes a register |
| id_mem_rd_i | input | 1 | Decode instruction is a load |
| id_dst_rt_i | input | 1 | 1: destination is `rt`, 0: destination is `rd` |
| fwd_a_o | output | 2 | Execute operand A select (00 file, 01 writeback, 10 memory) |
| fwd_b_o | output | 2 | Execute operand B select (same encoding) |
| id_byp_a_o | output | 1 | Decode `rs` read takes the writeback value |
| id_byp_b_o | output | 1 | Decode `rt` read takes the writeback value |
| pc_hold_o | output | 1 | Hold the program counter |
| ifid_hold_o | output | 1 | Hold the decode pipeline register |
| ex_flush_o | output | 1 | Load a bubble into execute |

## Verification
The bench sweeps long dependent streams drawn from a four-register pool, including register 0. This makes back-to-back, distance-two and distance-three dependencies, double matches and loads feeding their next instruction occur constantly. A design that picked the destination field from the wrong format would forward to the wrong consumer. One that gave writeback priority would pass an older value. One that forwarded register 0, or a producer with its write disabled, would corrupt a hard-wired zero read. A stall longer than one cycle, or one without a bubble, would show up as a repeated hold or as the held instruction being compared twice.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  parameter int REG_AW = 5;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_pipe_track.sv
module hzd_pipe_track #(
  parameter int REG_AW = hzd_pkg::REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs_i,
  input  logic [REG_AW-1:0] id_rt_i,
  input  logic [REG_AW-1:0] id_rd_i,
  input  logic              id_we_i,
  input  logic              id_mr_i,
  input  logic              id_dst_rt_i,
  input  logic              bubble_i,
  output logic [REG_AW-1:0] ex_rs_o,
  output logic [REG_AW-1:0] ex_rt_o,
  output logic [REG_AW-1:0] ex_dst_o,
  output logic              ex_we_o,
  output logic              ex_mr_o,
  output logic [REG_AW-1:0] mem_dst_o,
  output logic              mem_we_o,
  output logic [REG_AW-1:0] wb_dst_o,
  output logic              wb_we_o
);
  logic [REG_AW-1:0] id_dst;
  assign id_dst = id_dst_rt_i ? id_rt_i : id_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_rs_o   <= '0;
      ex_rt_o   <= '0;
      ex_dst_o  <= '0;
      ex_we_o   <= 1'b0;
      ex_mr_o   <= 1'b0;
      mem_dst_o <= '0;
      mem_we_o  <= 1'b0;
      wb_dst_o  <= '0;
      wb_we_o   <= 1'b0;
    end else begin
      if (bubble_i) begin
        ex_rs_o  <= '0;
        ex_rt_o  <= '0;
        ex_dst_o <= '0;
        ex_we_o  <= 1'b0;
        ex_mr_o  <= 1'b0;
      end else begin
        ex_rs_o  <= id_rs_i;
        ex_rt_o  <= id_rt_i;
        ex_dst_o <= id_dst;
        ex_we_o  <= id_we_i;
        ex_mr_o  <= id_mr_i;
      end
      mem_dst_o <= ex_dst_o;
      mem_we_o  <= ex_we_o;
      wb_dst_o  <= mem_dst_o;
      wb_we_o   <= mem_we_o;
    end
  end

  assert_bubble_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_i |=> (!ex_we_o && !ex_mr_o));
  assert_dest_travels_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_we_o |=> (mem_we_o && mem_dst_o == $past(ex_dst_o)));
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel #(
  parameter int REG_AW = hzd_pkg::REG_AW,
  parameter int NSRC   = 2,
  parameter int NPROD  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NSRC-1:0][REG_AW-1:0]  src_i,
  input  logic [NPROD-1:0][REG_AW-1:0] prod_dst_i,
  input  logic [NPROD-1:0]             prod_we_i,
  output logic [NSRC-1:0][NPROD-1:0]   pri_o
);
  // index 0 is the youngest producer and has the highest priority
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [NPROD-1:0] sel;
    always_comb begin
      sel = '0;
      for (int p = NPROD - 1; p >= 0; p--) begin
        if (prod_we_i[p] && (prod_dst_i[p] != '0) && (prod_dst_i[p] == src_i[s])) begin
          sel    = '0;
          sel[p] = 1'b1;
        end
      end
    end
    assign pri_o[s] = sel;

    assert_pri_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(pri_o[s]));
    assert_no_zero_fwd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|pri_o[s]) |-> (src_i[s] != '0));
  end
endmodule

// File: rtl/hzd_load_stall.sv
module hzd_load_stall #(
  parameter int REG_AW = hzd_pkg::REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs_i,
  input  logic [REG_AW-1:0] id_rt_i,
  input  logic [REG_AW-1:0] ex_dst_i,
  input  logic              ex_we_i,
  input  logic              ex_mr_i,
  output logic              stall_o
);
  logic ld_live;
  assign ld_live = ex_mr_i && ex_we_i && (ex_dst_i != '0);
  assign stall_o = ld_live && ((ex_dst_i == id_rs_i) || (ex_dst_i == id_rt_i));

  assert_single_bubble_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int AW = hzd_pkg::REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic [AW-1:0] id_rd_i,
  input  logic          id_reg_we_i,
  input  logic          id_mem_rd_i,
  input  logic          id_dst_rt_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          id_byp_a_o,
  output logic          id_byp_b_o,
  output logic          pc_hold_o,
  output logic          ifid_hold_o,
  output logic          ex_flush_o
);
  localparam int NSRC = 2;

  logic [AW-1:0] ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
  logic          ex_we, ex_mr, mem_we, wb_we, stall;
  logic [NSRC-1:0][1:0] ex_pri;
  logic [NSRC-1:0][0:0] id_pri;
  fwd_sel_e sel_a, sel_b;

  hzd_pipe_track #(.REG_AW(AW)) u_track (
    .clk_i, .rst_ni,
    .id_rs_i, .id_rt_i, .id_rd_i,
    .id_we_i(id_reg_we_i), .id_mr_i(id_mem_rd_i), .id_dst_rt_i,
    .bubble_i(stall),
    .ex_rs_o(ex_rs), .ex_rt_o(ex_rt), .ex_dst_o(ex_dst),
    .ex_we_o(ex_we), .ex_mr_o(ex_mr),
    .mem_dst_o(mem_dst), .mem_we_o(mem_we),
    .wb_dst_o(wb_dst), .wb_we_o(wb_we)
  );

  hzd_fwd_sel #(.REG_AW(AW), .NSRC(NSRC), .NPROD(2)) u_ex_fwd (
    .clk_i, .rst_ni,
    .src_i({ex_rt, ex_rs}),
    .prod_dst_i({wb_dst, mem_dst}),
    .prod_we_i({wb_we, mem_we}),
    .pri_o(ex_pri)
  );

  hzd_fwd_sel #(.REG_AW(AW), .NSRC(NSRC), .NPROD(1)) u_id_byp (
    .clk_i, .rst_ni,
    .src_i({id_rt_i, id_rs_i}),
    .prod_dst_i(wb_dst),
    .prod_we_i(wb_we),
    .pri_o(id_pri)
  );

  hzd_load_stall #(.REG_AW(AW)) u_stall (
    .clk_i, .rst_ni,
    .id_rs_i, .id_rt_i,
    .ex_dst_i(ex_dst), .ex_we_i(ex_we), .ex_mr_i(ex_mr),
    .stall_o(stall)
  );

  assign sel_a = ex_pri[0][0] ? FWD_MEM : (ex_pri[0][1] ? FWD_WB : FWD_RF);
  assign sel_b = ex_pri[1][0] ? FWD_MEM : (ex_pri[1][1] ? FWD_WB : FWD_RF);

  assign fwd_a_o     = sel_a;
  assign fwd_b_o     = sel_b;
  assign id_byp_a_o  = id_pri[0][0];
  assign id_byp_b_o  = id_pri[1][0];
  assign pc_hold_o   = stall;
  assign ifid_hold_o = stall;
  assign ex_flush_o  = stall;

  assert_wb_fwd_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o == FWD_WB || fwd_b_o == FWD_WB || id_byp_a_o || id_byp_b_o) |-> wb_we);
  assert_mem_fwd_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o == FWD_MEM || fwd_b_o == FWD_MEM) |-> mem_we);
  assert_after_load_wb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> !ex_we);
endmodule

// File: tb/tb_hzd_unit.sv
`timescale 1ns/1ps
module tb_hzd_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] id_rs, id_rt, id_rd;
  logic       id_we, id_mr, id_dst_rt;
  logic [1:0] fwd_a, fwd_b;
  logic       byp_a, byp_b, pc_hold, ifid_hold, ex_flush;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hzd_unit dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .id_rs_i(id_rs), .id_rt_i(id_rt), .id_rd_i(id_rd),
    .id_reg_we_i(id_we), .id_mem_rd_i(id_mr), .id_dst_rt_i(id_dst_rt),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
    .id_byp_a_o(byp_a), .id_byp_b_o(byp_b),
    .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold), .ex_flush_o(ex_flush)
  );

  // scoreboard state
  logic [4:0] m_ex_rs, m_ex_rt, m_ex_dst, m_mem_dst, m_wb_dst;
  logic       m_ex_we, m_ex_mr, m_mem_we, m_wb_we;
  int         stall_run;

  function automatic logic [1:0] exp_sel(input logic [4:0] s);
    if (m_mem_we && m_mem_dst != 0 && m_mem_dst == s) return 2'b10;
    if (m_wb_we && m_wb_dst != 0 && m_wb_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_byp(input logic [4:0] s);
    return m_wb_we && m_wb_dst != 0 && m_wb_dst == s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ex_rs = 0; m_ex_rt = 0; m_ex_dst = 0; m_mem_dst = 0; m_wb_dst = 0;
    m_ex_we = 0; m_ex_mr = 0; m_mem_we = 0; m_wb_we = 0; stall_run = 0;
  endtask

  // one cycle: inputs already driven at negedge; compare, then advance model
  task automatic step();
    logic e_stall;
    #1;
    vectors++;
    e_stall = m_ex_mr && m_ex_we && m_ex_dst != 0 &&
              (m_ex_dst == id_rs || m_ex_dst == id_rt);
    check("R1 R2 R3 R4 R5 R6 fwd_a", fwd_a, exp_sel(m_ex_rs));
    check("R1 R2 R3 R4 R5 R6 fwd_b", fwd_b, exp_sel(m_ex_rt));
    check("R7 byp_a", byp_a, exp_byp(id_rs));
    check("R7 byp_b", byp_b, exp_byp(id_rt));
    check("R8 pc_hold", pc_hold, e_stall);
    check("R8 ifid_hold", ifid_hold, e_stall);
    check("R8 ex_flush", ex_flush, e_stall);
    stall_run = e_stall ? stall_run + 1 : 0;
    check("R8 stall length", stall_run > 1, 0);
    m_wb_dst = m_mem_dst; m_wb_we = m_mem_we;
    m_mem_dst = m_ex_dst; m_mem_we = m_ex_we;
    if (e_stall) begin
      m_ex_rs = 0; m_ex_rt = 0; m_ex_dst = 0; m_ex_we = 0; m_ex_mr = 0;
    end else begin
      m_ex_rs = id_rs; m_ex_rt = id_rt;
      m_ex_dst = id_dst_rt ? id_rt : id_rd;
      m_ex_we = id_we; m_ex_mr = id_mr;
    end
  endtask

  task automatic drive(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd,
                       input logic we, input logic mr, input logic dr);
    @(negedge clk);
    id_rs = rs; id_rt = rt; id_rd = rd; id_we = we; id_mr = mr; id_dst_rt = dr;
    step();
  endtask

  initial begin
    id_rs = 0; id_rt = 0; id_rd = 0; id_we = 0; id_mr = 0; id_dst_rt = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R10: empty pipeline after reset
    #1;
    vectors++;
    check("R10 fwd_a", fwd_a, 0);
    check("R10 fwd_b", fwd_b, 0);
    check("R10 hold", {byp_a, byp_b, pc_hold, ifid_hold, ex_flush}, 0);

    // directed: R1 rd destination, forward from mem then wb
    drive(5'd1, 5'd2, 5'd7, 1, 0, 0);      // writes r7
    drive(5'd7, 5'd7, 5'd9, 1, 0, 1);      // writes rt=r7 again, reads r7
    drive(5'd7, 5'd0, 5'd3, 0, 0, 0);      // R4: mem and wb both r7
    drive(5'd0, 5'd0, 5'd0, 1, 0, 0);      // R5 r0 destination
    drive(5'd0, 5'd0, 5'd0, 0, 0, 0);
    // R8 R9: load r5 then dependent
    drive(5'd1, 5'd5, 5'd0, 1, 1, 1);
    drive(5'd5, 5'd2, 5'd4, 1, 0, 0);      // stall cycle
    drive(5'd5, 5'd2, 5'd4, 1, 0, 0);      // held instruction enters
    drive(5'd0, 5'd0, 5'd0, 0, 0, 0);      // R9: ex source r5 gets wb path
    // R6: load with write disabled never stalls
    drive(5'd1, 5'd6, 5'd0, 0, 1, 1);
    drive(5'd6, 5'd6, 5'd0, 0, 0, 0);
    // R5: load to r0 never stalls
    drive(5'd1, 5'd0, 5'd0, 1, 1, 1);
    drive(5'd0, 5'd0, 5'd0, 0, 0, 0);

    // sweep over a small register pool
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (!(stall_run > 0)) begin
        id_rs = 5'($urandom_range(0, 3));
        id_rt = 5'($urandom_range(0, 3));
        id_rd = 5'($urandom_range(0, 3));
        id_we = 1'($urandom_range(0, 3) != 0);
        id_mr = 1'($urandom_range(0, 2) == 0);
        id_dst_rt = id_mr ? 1'b1 : 1'($urandom_range(0, 1));
      end
      step();
    end

    // reset in mid-stream returns to empty state (R10)
    @(negedge clk);
    rst_ni = 1'b0;
    model_reset();
    #1;
    vectors++;
    check("R10 async reset", {fwd_a, fwd_b, pc_hold, ex_flush}, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule